// File: doc/BRIEF.md
# Pulse-distance remote control decoder

This block turns a demodulated infrared remote-control signal into button codes. The input is a synchronous level, high while light is received. Every symbol is a one-unit mark followed by a space. The length of the space carries the bit: one unit means 0, three units mean 1. The `UNIT_CLKS` parameter sets the length of one unit in clocks.

A transmission starts with a long steady mark. This wake-up mark also acts as the leading mark of the first packet. While the key is held, the packet repeats after a long gap. In each packet the first `ID_BITS` bits form an identifier field. The remaining bits form a data field, and both fields are received least significant bit first.

The decoder pulses `code_valid` when a new code completes and holds it on `code_id`, `code_data` and `code_len`. It raises `key_held` while further packets repeat the same code. Once the line has been quiet for a while, the session ends and a new wake-up mark is needed.

Top module: `ir_pd_decoder`

## Requirements
- R1: During and after reset, before any packet, `code_valid` and `key_held` are 0 and `code_id`, `code_data`, `code_len` are all zero.
- R2: While no session is open, no symbol is decoded. Marks shorter than `WAKE_UNITS` units produce no code. A mark of at least `WAKE_UNITS` units opens a session and counts as the leading mark of a packet.
- R3: The space that ends at the next rising edge decides the bit. A space shorter than 2 units decodes as 0. A space of 2 up to `GAP_UNITS` units decodes as 1, so the nominal 3-unit space is a 1.
- R4: The first `ID_BITS` bits of a packet form `code_id`, and the first bit received goes to bit 0.
- R5: The bits after the identifier form `code_data`, first bit received at bit 0. `code_len` gives their count, and bits of `code_data` at or above `code_len` are 0. For example, data bits 1,0,1,0 give value 5 with length 4.
- R6: A packet ends when a space grows longer than `GAP_UNITS` units. The mark before that gap terminates the packet and carries no bit.
- R7: A packet holding `ID_BITS` bits or fewer is dropped. The outputs stay unchanged and no strobe is given.
- R8: `code_valid` is a one-cycle pulse. It fires on the first complete packet of a session and on any packet whose identifier, data or length differs from the held code. The code outputs change only together with this pulse.
- R9: A complete packet equal to the held code gives no pulse and sets `key_held`. `key_held` stays high while equal packets keep arriving.
- R10: When the line stays low for `HOLD_UNITS` units after the last terminating mark, `key_held` clears and the session closes. A following packet without a wake-up mark is then ignored. The same code after a new wake-up mark pulses `code_valid` again.
- R11: Data bits beyond `DATA_MAX` are discarded, and `code_len` never exceeds `DATA_MAX`.
- R12: A mark of at least `WAKE_UNITS` units inside a packet discards the bits received so far and starts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_in | input | 1 | Demodulated light level, 1 while light is received |
| code_valid | output | 1 | One-cycle pulse when a new code is presented |
| code_id | output | ID_BITS | Identifier field of the held code |
| code_data | output | DATA_MAX | Data field of the held code, least significant bit first on the line |
| code_len | output | $clog2(DATA_MAX+1) | Number of data bits in the held code |
| key_held | output | 1 | High while matching packets repeat |

## Verification
The hardest state to reach from the ports is a session that has timed out with a repeated code still latched on the outputs. After the timeout, a packet with no wake-up mark must be ignored, and the same code behind a fresh wake-up mark must strobe again. The stimulus gets there in stages. It builds a held repeat, sends a packet that is too short and must be dropped, and then keeps the line low past the hold window. Finally it replays that packet with and without a wake-up mark. A packet broken by a second long mark, and a packet longer than the data field, reach the restart and overflow paths.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RX    = 2'd2
  } rx_state_e;
endpackage

// File: rtl/ir_rst_sync.sv
module ir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
  parameter int UNIT_CLKS = 16,
  parameter int RUN_MAX   = 33,
  localparam int PRE_W    = $clog2(UNIT_CLKS),
  localparam int RUN_W    = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  output logic             lvl,
  output logic             rise,
  output logic             fall,
  output logic [RUN_W-1:0] run
);
  logic             ir_q, ir_d;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [RUN_W-1:0] run_q, run_nxt;
  logic             edge_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= 1'b0;
      ir_d <= 1'b0;
    end else begin
      ir_q <= ir_in;
      ir_d <= ir_q;
    end
  end

  assign edge_now = ir_q ^ ir_d;

  always_comb begin
    pre_nxt = pre_q;
    run_nxt = run_q;
    if (edge_now) begin
      pre_nxt = PRE_W'(1);
      run_nxt = '0;
    end else if (pre_q == PRE_W'(UNIT_CLKS - 1)) begin
      pre_nxt = '0;
      if (run_q != RUN_W'(RUN_MAX)) run_nxt = run_q + RUN_W'(1);
    end else begin
      pre_nxt = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      run_q <= '0;
    end else begin
      pre_q <= pre_nxt;
      run_q <= run_nxt;
    end
  end

  assign lvl  = ir_q;
  assign rise = ir_q & ~ir_d;
  assign fall = ~ir_q & ir_d;
  assign run  = run_q;
endmodule

// File: rtl/ir_symbol_fsm.sv
module ir_symbol_fsm
  import ir_pd_pkg::*;
#(
  parameter int ID_BITS    = 8,
  parameter int DATA_MAX   = 16,
  parameter int RUN_W      = 6,
  parameter int WAKE_UNITS = 8,
  parameter int GAP_UNITS  = 6,
  parameter int HOLD_UNITS = 32,
  localparam int TOT       = ID_BITS + DATA_MAX,
  localparam int CNT_W     = $clog2(TOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  input  logic [RUN_W-1:0] run,
  output logic             pkt_done,
  output logic [TOT-1:0]   pkt_bits,
  output logic [CNT_W-1:0] pkt_cnt,
  output logic             sess_end
);
  rx_state_e        st_q, st_nxt;
  logic [TOT-1:0]   bits_q, bits_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             long_mark, gap_seen, hold_seen, space_one;

  assign long_mark = fall && (run >= RUN_W'(WAKE_UNITS));
  assign gap_seen  = !lvl && (run > RUN_W'(GAP_UNITS));
  assign hold_seen = !lvl && (run >= RUN_W'(HOLD_UNITS));
  assign space_one = (run >= RUN_W'(2));

  always_comb begin
    st_nxt   = st_q;
    bits_nxt = bits_q;
    cnt_nxt  = cnt_q;
    pkt_done = 1'b0;
    sess_end = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (long_mark) begin
          st_nxt   = ST_RX;
          bits_nxt = '0;
          cnt_nxt  = '0;
        end
      end
      ST_ARMED: begin
        if (rise) begin
          st_nxt   = ST_RX;
          bits_nxt = '0;
          cnt_nxt  = '0;
        end else if (hold_seen) begin
          st_nxt   = ST_IDLE;
          sess_end = 1'b1;
        end
      end
      ST_RX: begin
        if (rise) begin
          if (cnt_q < CNT_W'(TOT)) begin
            bits_nxt[cnt_q] = space_one;
            cnt_nxt         = cnt_q + CNT_W'(1);
          end
        end else if (long_mark) begin
          bits_nxt = '0;
          cnt_nxt  = '0;
        end else if (gap_seen) begin
          st_nxt   = ST_ARMED;
          pkt_done = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_nxt;
      bits_q <= bits_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign pkt_bits = bits_q;
  assign pkt_cnt  = cnt_q;
endmodule

// File: rtl/ir_repeat_tracker.sv
module ir_repeat_tracker #(
  parameter int ID_BITS  = 8,
  parameter int DATA_MAX = 16,
  localparam int TOT     = ID_BITS + DATA_MAX,
  localparam int CNT_W   = $clog2(TOT + 1),
  localparam int LEN_W   = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_done,
  input  logic [TOT-1:0]      pkt_bits,
  input  logic [CNT_W-1:0]    pkt_cnt,
  input  logic                sess_end,
  output logic                code_valid,
  output logic [ID_BITS-1:0]  code_id,
  output logic [DATA_MAX-1:0] code_data,
  output logic [LEN_W-1:0]    code_len,
  output logic                key_held
);
  logic                have_q, have_nxt;
  logic                held_q, held_nxt;
  logic                vld_q, vld_nxt;
  logic                load_en;
  logic [ID_BITS-1:0]  id_q, new_id;
  logic [DATA_MAX-1:0] data_q, new_data;
  logic [LEN_W-1:0]    len_q, new_len;
  logic                pkt_ok, same;

  assign pkt_ok   = pkt_done && (pkt_cnt > CNT_W'(ID_BITS));
  assign new_id   = pkt_bits[ID_BITS-1:0];
  assign new_data = pkt_bits[TOT-1:ID_BITS];
  assign new_len  = LEN_W'(pkt_cnt - CNT_W'(ID_BITS));
  assign same     = have_q && (id_q == new_id) && (data_q == new_data)
                    && (len_q == new_len);

  always_comb begin
    have_nxt = have_q;
    held_nxt = held_q;
    vld_nxt  = 1'b0;
    load_en  = 1'b0;
    if (sess_end) begin
      have_nxt = 1'b0;
      held_nxt = 1'b0;
    end else if (pkt_ok) begin
      if (same) begin
        held_nxt = 1'b1;
      end else begin
        vld_nxt  = 1'b1;
        load_en  = 1'b1;
        have_nxt = 1'b1;
        held_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      held_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      have_q <= have_nxt;
      held_q <= held_nxt;
      vld_q  <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      data_q <= '0;
      len_q  <= '0;
    end else if (load_en) begin
      id_q   <= new_id;
      data_q <= new_data;
      len_q  <= new_len;
    end
  end

  assign code_valid = vld_q;
  assign code_id    = id_q;
  assign code_data  = data_q;
  assign code_len   = len_q;
  assign key_held   = held_q;
endmodule

// File: rtl/ir_pd_decoder.sv
module ir_pd_decoder #(
  parameter int UNIT_CLKS  = 16,
  parameter int ID_BITS    = 8,
  parameter int DATA_MAX   = 16,
  parameter int WAKE_UNITS = 8,
  parameter int GAP_UNITS  = 6,
  parameter int HOLD_UNITS = 32,
  localparam int LEN_W     = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ir_in,
  output logic                code_valid,
  output logic [ID_BITS-1:0]  code_id,
  output logic [DATA_MAX-1:0] code_data,
  output logic [LEN_W-1:0]    code_len,
  output logic                key_held
);
  localparam int TOT     = ID_BITS + DATA_MAX;
  localparam int CNT_W   = $clog2(TOT + 1);
  localparam int RUN_MAX = HOLD_UNITS + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic             rst_sync_n;
  logic             lvl, rise, fall;
  logic [RUN_W-1:0] run;
  logic             pkt_done, sess_end;
  logic [TOT-1:0]   pkt_bits;
  logic [CNT_W-1:0] pkt_cnt;

  ir_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ir_edge_timer #(.UNIT_CLKS(UNIT_CLKS), .RUN_MAX(RUN_MAX)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ir_in (ir_in),
    .lvl   (lvl),
    .rise  (rise),
    .fall  (fall),
    .run   (run)
  );

  ir_symbol_fsm #(
    .ID_BITS(ID_BITS), .DATA_MAX(DATA_MAX), .RUN_W(RUN_W),
    .WAKE_UNITS(WAKE_UNITS), .GAP_UNITS(GAP_UNITS), .HOLD_UNITS(HOLD_UNITS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lvl      (lvl),
    .rise     (rise),
    .fall     (fall),
    .run      (run),
    .pkt_done (pkt_done),
    .pkt_bits (pkt_bits),
    .pkt_cnt  (pkt_cnt),
    .sess_end (sess_end)
  );

  ir_repeat_tracker #(.ID_BITS(ID_BITS), .DATA_MAX(DATA_MAX)) u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pkt_done   (pkt_done),
    .pkt_bits   (pkt_bits),
    .pkt_cnt    (pkt_cnt),
    .sess_end   (sess_end),
    .code_valid (code_valid),
    .code_id    (code_id),
    .code_data  (code_data),
    .code_len   (code_len),
    .key_held   (key_held)
  );
endmodule

// File: rtl/ir_pd_decoder_chk.sv
module ir_pd_decoder_chk #(
  parameter int ID_BITS  = 8,
  parameter int DATA_MAX = 16,
  localparam int LEN_W   = $clog2(DATA_MAX + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                code_valid,
  input logic [ID_BITS-1:0]  code_id,
  input logic [DATA_MAX-1:0] code_data,
  input logic [LEN_W-1:0]    code_len,
  input logic                key_held
);
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> !code_valid);

  p_outputs_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |-> ($stable(code_id) && $stable(code_data) && $stable(code_len)));

  p_strobe_clears_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> !key_held);

  p_held_needs_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    key_held |-> (code_len != '0));

  p_held_rise_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_held) |-> !code_valid);

  p_len_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    code_len <= LEN_W'(DATA_MAX));

  p_data_above_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_data >> code_len) == '0);
endmodule

bind ir_pd_decoder ir_pd_decoder_chk #(.ID_BITS(ID_BITS), .DATA_MAX(DATA_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_valid (code_valid),
  .code_id    (code_id),
  .code_data  (code_data),
  .code_len   (code_len),
  .key_held   (key_held)
);

// File: tb/ir_pd_decoder_tb.sv
module ir_pd_decoder_tb;
  localparam int UNIT  = 4;
  localparam int IDB   = 8;
  localparam int DMAX  = 16;
  localparam int WAKE  = 8;
  localparam int GAP   = 6;
  localparam int HOLD  = 32;
  localparam int LEN_W = $clog2(DMAX + 1);

  logic            clk, rst_n, ir_in;
  logic            code_valid, key_held;
  logic [IDB-1:0]  code_id;
  logic [DMAX-1:0] code_data;
  logic [LEN_W-1:0] code_len;

  int checks, errors, strobes;
  logic [31:0] last_id, last_data, last_len;
  bit done;

  ir_pd_decoder #(.UNIT_CLKS(UNIT), .ID_BITS(IDB), .DATA_MAX(DMAX),
    .WAKE_UNITS(WAKE), .GAP_UNITS(GAP), .HOLD_UNITS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .code_valid(code_valid),
    .code_id(code_id), .code_data(code_data), .code_len(code_len),
    .key_held(key_held));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (code_valid) begin
      strobes   = strobes + 1;
      last_id   = 32'(code_id);
      last_data = 32'(code_data);
      last_len  = 32'(code_len);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic level(input logic v, input int units);
    ir_in = v;
    repeat (units * UNIT) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      level(1'b1, 1);
      level(1'b0, v[i] ? 3 : 1);
    end
  endtask

  task automatic send_packet(input bit wake, input logic [31:0] v, input int n);
    level(1'b1, wake ? WAKE + 2 : 1);
    send_bits(v, n);
    level(1'b1, 1);
    level(1'b0, GAP + 3);
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(code_valid), 0);
    chk("R1 held", 32'(key_held), 0);
    chk("R1 id", 32'(code_id), 0);
    chk("R1 data", 32'(code_data), 0);
    chk("R1 len", 32'(code_len), 0);
  endtask

  task automatic t_no_wake;
    int s0 = strobes;
    send_packet(1'b0, {20'h0, 4'h5, 8'h5A}, 12);
    chk("R2 no strobe without wake", 32'(strobes - s0), 0);
  endtask

  task automatic t_basic;
    int s0 = strobes;
    send_packet(1'b1, {20'h0, 4'h5, 8'h5A}, 12);
    chk("R8 first strobe", 32'(strobes - s0), 1);
    chk("R4 id", last_id, 32'h5A);
    chk("R5 data 1010 lsb first", last_data, 5);
    chk("R6 len excludes stop mark", last_len, 4);
    chk("R9 held low on first", 32'(key_held), 0);
  endtask

  task automatic t_repeat;
    int s0 = strobes;
    send_packet(1'b0, {20'h0, 4'h5, 8'h5A}, 12);
    chk("R9 held after repeat", 32'(key_held), 1);
    send_packet(1'b0, {20'h0, 4'h5, 8'h5A}, 12);
    chk("R9 held stays", 32'(key_held), 1);
    chk("R8 no strobe on repeat", 32'(strobes - s0), 0);
  endtask

  task automatic t_change;
    int s0 = strobes;
    send_packet(1'b0, {20'h0, 4'h9, 8'h5A}, 12);
    chk("R8 strobe on change", 32'(strobes - s0), 1);
    chk("R8 data changed", last_data, 9);
    chk("R8 held cleared", 32'(key_held), 0);
  endtask

  task automatic t_symbols;
    send_packet(1'b0, {21'h0, 3'h0, 8'hFF}, 11);
    chk("R3 long spaces are ones", last_id, 32'hFF);
    chk("R3 short spaces are zeros", last_data, 0);
    chk("R3 len", last_len, 3);
  endtask

  task automatic t_long;
    send_packet(1'b0, {20'hABCDE, 8'h33} , 28);
    chk("R11 len saturates", last_len, DMAX);
    chk("R11 data truncated", last_data, 32'hBCDE);
    chk("R11 id", last_id, 32'h33);
  endtask

  task automatic t_restart;
    int s0 = strobes;
    level(1'b1, WAKE + 2);
    send_bits(32'h7, 3);
    send_packet(1'b1, {22'h0, 2'h2, 8'h0F}, 10);
    chk("R12 one strobe", 32'(strobes - s0), 1);
    chk("R12 id of new packet", last_id, 32'h0F);
    chk("R12 data of new packet", last_data, 2);
    chk("R12 len", last_len, 2);
  endtask

  task automatic t_short;
    int s0 = strobes;
    send_packet(1'b0, {22'h0, 2'h2, 8'h0F}, 10);
    chk("R9 held before short", 32'(key_held), 1);
    send_packet(1'b0, 32'h3F, 6);
    chk("R7 short dropped", 32'(strobes - s0), 0);
    chk("R7 id unchanged", 32'(code_id), 32'h0F);
    chk("R7 len unchanged", 32'(code_len), 2);
  endtask

  task automatic t_timeout;
    int s0;
    level(1'b0, HOLD + 4);
    chk("R10 held cleared by timeout", 32'(key_held), 0);
    s0 = strobes;
    send_packet(1'b0, {22'h0, 2'h2, 8'h0F}, 10);
    chk("R10 no session no strobe", 32'(strobes - s0), 0);
    chk("R10 held stays low", 32'(key_held), 0);
    send_packet(1'b1, {22'h0, 2'h2, 8'h0F}, 10);
    chk("R10 same code strobes in new session", 32'(strobes - s0), 1);
  endtask

  initial begin
    checks = 0; errors = 0; strobes = 0; done = 0;
    last_id = 0; last_data = 0; last_len = 0;
    ir_in = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_no_wake;
    t_basic;
    t_repeat;
    t_change;
    t_symbols;
    t_long;
    t_restart;
    t_short;
    t_timeout;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule